// File: doc/BRIEF.md
# Clock and Reset Control Register Bank

This block is the software-visible register bank of a power, reset and clock controller. A host reaches it over a 32-bit APB-style bus decoding a 4 KiB offset window. The bank holds an oscillator setup word, three phase-locked-loop settings (core, memory and Ethernet; each has a primary word, and the memory and Ethernet loops also have a secondary word), a core clock source selector, a peripheral reset word and a clock multiplexer status word. Every register value is driven out on its own port for use elsewhere in the chip.

There are no real oscillators or loops behind the bank. It only mimics what software expects to see. Writes to the oscillator word always leave its ready flag set. Writes to any loop primary word always leave its lock flag and internal-feedback flag set. Unmapped offsets read as zero and ignore writes. Such accesses, and any access with fewer than all four byte strobes, still complete with no wait state. They raise a one-cycle error flag.

Top module: `prci_ctrl_regs`

## Requirements
- R1: After reset, the registers hold these values:
  - oscillator word (offset 0x00): 0xC000_0000 (bit 31 ready, bit 30 enable);
  - each loop primary word: 0x8201_87C1 (reference divider 1 at bit 0, feedback divider 31 from bit 6, output divider 3 from bit 15, feedback flag at bit 25, lock flag at bit 31);
  - clock selector: 0x0000_0001 (core on the reference clock);
  - all other registers: zero.
- R2: The registers sit at these byte offsets:
  - 0x00 oscillator;
  - 0x04 core loop primary;
  - 0x0C memory loop primary;
  - 0x10 memory loop secondary;
  - 0x1C Ethernet loop primary;
  - 0x20 Ethernet loop secondary;
  - 0x24 clock selector;
  - 0x28 peripheral reset;
  - 0x2C mux status.
  Every other offset, including unaligned ones, is unmapped.
- R3: A write to the oscillator word stores the written data with bit 31 forced to 1.
- R4: A write to any loop primary word stores the written data with bits 25 and 31 forced to 1.
- R5: Writes to the two secondary words, the clock selector, the peripheral reset word and the mux status word are stored exactly as written.
- R6: During the access phase of a read, `prdata` shows the addressed register. An unmapped offset reads as zero.
- R7: A write to an unmapped offset changes no register.
- R8: An access with `pstrb` not equal to 4'hF is rejected. A rejected write changes no register, and a rejected read returns zero.
- R9: `pready` is always 1. `access_err` is high for exactly the one cycle after the access phase of an unmapped or strobe-rejected access, and low otherwise.
- R10: Register output ports take a written value on the clock edge that ends the write's access phase. They show the old value during that access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Bus select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte strobes; all must be set |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| access_err | output | 1 | One-cycle error flag for rejected accesses |
| osc_cfg_o | output | 32 | Oscillator word |
| core_pll_cfg0_o | output | 32 | Core loop primary word |
| ddr_pll_cfg0_o | output | 32 | Memory loop primary word |
| ddr_pll_cfg1_o | output | 32 | Memory loop secondary word |
| eth_pll_cfg0_o | output | 32 | Ethernet loop primary word |
| eth_pll_cfg1_o | output | 32 | Ethernet loop secondary word |
| clk_sel_o | output | 32 | Core clock selector |
| dev_rst_o | output | 32 | Peripheral reset word |
| mux_status_o | output | 32 | Clock mux status word |

## Verification
The forced flags are the hardest behaviour to observe, because a plain write-then-read pass cannot tell a forced bit from a bit that software happened to write as 1. The vector table therefore writes values with the ready, lock and feedback bits cleared, then reads each register back and expects those bits set.

Rejected accesses are driven with a partial strobe or an unaligned offset aimed at a live register. The bench then confirms through the output ports that the register kept its earlier value. It also confirms that the error flag lasted a single cycle.

// File: rtl/prci_regs_pkg.sv
package prci_regs_pkg;

    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 12;
    localparam int STRB_W   = DATA_W / 8;
    localparam int NUM_REGS = 9;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] offs_t;

    typedef enum logic [IDX_W-1:0] {
        RG_OSC    = 0,
        RG_CPLL0  = 1,
        RG_DPLL0  = 2,
        RG_DPLL1  = 3,
        RG_EPLL0  = 4,
        RG_EPLL1  = 5,
        RG_CLKSEL = 6,
        RG_DEVRST = 7,
        RG_MUXST  = 8
    } reg_id_e;

    localparam int OSC_RDY_BIT  = 31;
    localparam int OSC_EN_BIT   = 30;
    localparam int PLL_LOCK_BIT = 31;
    localparam int PLL_FSE_BIT  = 25;
    localparam int PLL_DIVQ_LSB = 15;
    localparam int PLL_DIVF_LSB = 6;

    localparam word_t OSC_RST = (word_t'(1) << OSC_RDY_BIT) | (word_t'(1) << OSC_EN_BIT);
    localparam word_t PLL_RST = word_t'(1)
                              | (word_t'(31) << PLL_DIVF_LSB)
                              | (word_t'(3)  << PLL_DIVQ_LSB)
                              | (word_t'(1)  << PLL_FSE_BIT)
                              | (word_t'(1)  << PLL_LOCK_BIT);
    localparam word_t OSC_FORCE = word_t'(1) << OSC_RDY_BIT;
    localparam word_t PLL_FORCE = (word_t'(1) << PLL_FSE_BIT) | (word_t'(1) << PLL_LOCK_BIT);

    typedef struct packed {
        logic                hit;
        logic [NUM_REGS-1:0] sel;
    } decode_t;

    function automatic offs_t offset_of(input int idx);
        case (idx)
            int'(RG_OSC):    return offs_t'(12'h000);
            int'(RG_CPLL0):  return offs_t'(12'h004);
            int'(RG_DPLL0):  return offs_t'(12'h00C);
            int'(RG_DPLL1):  return offs_t'(12'h010);
            int'(RG_EPLL0):  return offs_t'(12'h01C);
            int'(RG_EPLL1):  return offs_t'(12'h020);
            int'(RG_CLKSEL): return offs_t'(12'h024);
            int'(RG_DEVRST): return offs_t'(12'h028);
            default:         return offs_t'(12'h02C);
        endcase
    endfunction

    function automatic logic is_pll_primary(input int idx);
        return (idx == int'(RG_CPLL0)) || (idx == int'(RG_DPLL0)) || (idx == int'(RG_EPLL0));
    endfunction

    function automatic word_t reset_of(input int idx);
        if (idx == int'(RG_OSC))    return OSC_RST;
        if (is_pll_primary(idx))    return PLL_RST;
        if (idx == int'(RG_CLKSEL)) return word_t'(1);
        return '0;
    endfunction

    function automatic word_t force_of(input int idx);
        if (idx == int'(RG_OSC)) return OSC_FORCE;
        if (is_pll_primary(idx)) return PLL_FORCE;
        return '0;
    endfunction

endpackage

// File: rtl/prci_addr_decode.sv
module prci_addr_decode
    import prci_regs_pkg::*;
(
    input  offs_t   addr,
    output decode_t dec
);
    always_comb begin
        dec.sel = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            dec.sel[i] = (addr == offset_of(i));
        end
        dec.hit = |dec.sel;
    end
endmodule

// File: rtl/prci_reg_slot.sv
module prci_reg_slot
    import prci_regs_pkg::*;
#(
    parameter word_t RST_VAL    = '0,
    parameter word_t FORCE_MASK = '0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wdata,
    output word_t q
);
    always_ff @(posedge clk) begin
        if (rst)        q <= RST_VAL;
        else if (wr_en) q <= wdata | FORCE_MASK;
    end

    // R10
    slot_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (q == ($past(wdata) | FORCE_MASK)));

    // R7
    slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q));

    generate
        if (FORCE_MASK != '0) begin : g_forced
            // R3 R4
            forced_bits_chk: assert property (@(posedge clk) disable iff (rst)
                (q & FORCE_MASK) == FORCE_MASK);
        end
    endgenerate
endmodule

// File: rtl/prci_ctrl_regs.sv
module prci_ctrl_regs
    import prci_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    input  logic [STRB_W-1:0] pstrb,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              access_err,
    output logic [DATA_W-1:0] osc_cfg_o,
    output logic [DATA_W-1:0] core_pll_cfg0_o,
    output logic [DATA_W-1:0] ddr_pll_cfg0_o,
    output logic [DATA_W-1:0] ddr_pll_cfg1_o,
    output logic [DATA_W-1:0] eth_pll_cfg0_o,
    output logic [DATA_W-1:0] eth_pll_cfg1_o,
    output logic [DATA_W-1:0] clk_sel_o,
    output logic [DATA_W-1:0] dev_rst_o,
    output logic [DATA_W-1:0] mux_status_o
);
    decode_t dec;
    word_t   regs [NUM_REGS];
    word_t   rd_mux;
    logic    strb_full;
    logic    acc_phase;
    logic    accept;
    logic    wr_accept;

    prci_addr_decode u_dec (.addr(paddr), .dec(dec));

    assign strb_full = (pstrb == {STRB_W{1'b1}});
    assign acc_phase = psel && penable;
    assign accept    = dec.hit && strb_full;
    assign wr_accept = acc_phase && pwrite && accept;

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_slot
            prci_reg_slot #(
                .RST_VAL    (reset_of(g)),
                .FORCE_MASK (force_of(g))
            ) u_slot (
                .clk   (clk),
                .rst   (rst),
                .wr_en (wr_accept && dec.sel[g]),
                .wdata (pwdata),
                .q     (regs[g])
            );
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (dec.sel[i]) rd_mux = rd_mux | regs[i];
        end
    end

    assign prdata = (psel && !pwrite && accept) ? rd_mux : '0;
    assign pready = 1'b1;

    always_ff @(posedge clk) begin
        if (rst) access_err <= 1'b0;
        else     access_err <= acc_phase && !accept;
    end

    assign osc_cfg_o       = regs[RG_OSC];
    assign core_pll_cfg0_o = regs[RG_CPLL0];
    assign ddr_pll_cfg0_o  = regs[RG_DPLL0];
    assign ddr_pll_cfg1_o  = regs[RG_DPLL1];
    assign eth_pll_cfg0_o  = regs[RG_EPLL0];
    assign eth_pll_cfg1_o  = regs[RG_EPLL1];
    assign clk_sel_o       = regs[RG_CLKSEL];
    assign dev_rst_o       = regs[RG_DEVRST];
    assign mux_status_o    = regs[RG_MUXST];

    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) regs_flat[i*DATA_W +: DATA_W] = regs[i];
    end

    // R7
    unmapped_write_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_phase && pwrite && !dec.hit) |=> $stable(regs_flat));

    // R8
    partial_strobe_inert_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_phase && pwrite && !strb_full) |=> $stable(regs_flat));

    // R9
    err_follows_access_chk: assert property (@(posedge clk) disable iff (rst)
        access_err |-> $past(acc_phase));

    // R6
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && !pwrite && !dec.hit) |-> (prdata == '0));

    // R1
    clksel_reset_chk: assert property (@(posedge clk)
        $fell(rst) |-> (clk_sel_o == word_t'(1) && dev_rst_o == '0));
endmodule

// File: tb/prci_ctrl_regs_bench.sv
`timescale 1ns/1ps
module prci_ctrl_regs_bench;
    logic        clk = 0;
    logic        rst = 1;
    logic        psel = 0, penable = 0, pwrite = 0;
    logic [11:0] paddr = 0;
    logic [31:0] pwdata = 0;
    logic [3:0]  pstrb = 0;
    logic [31:0] prdata;
    logic        pready, access_err;
    logic [31:0] osc_cfg_o, core_pll_cfg0_o, ddr_pll_cfg0_o, ddr_pll_cfg1_o;
    logic [31:0] eth_pll_cfg0_o, eth_pll_cfg1_o, clk_sel_o, dev_rst_o, mux_status_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    prci_ctrl_regs u_prci_ctrl_regs (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
        .pready(pready), .access_err(access_err),
        .osc_cfg_o(osc_cfg_o), .core_pll_cfg0_o(core_pll_cfg0_o),
        .ddr_pll_cfg0_o(ddr_pll_cfg0_o), .ddr_pll_cfg1_o(ddr_pll_cfg1_o),
        .eth_pll_cfg0_o(eth_pll_cfg0_o), .eth_pll_cfg1_o(eth_pll_cfg1_o),
        .clk_sel_o(clk_sel_o), .dev_rst_o(dev_rst_o), .mux_status_o(mux_status_o)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [3:0]  strb;
        logic [31:0] rd;
        logic        werr;
        logic        rerr;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{12'h000, 32'h1234_5678, 4'hF, 32'h9234_5678, 1'b0, 1'b0},
        '{12'h004, 32'h0000_0000, 4'hF, 32'h8200_0000, 1'b0, 1'b0},
        '{12'h00C, 32'h0000_FFFF, 4'hF, 32'h8200_FFFF, 1'b0, 1'b0},
        '{12'h010, 32'hDEAD_BEEF, 4'hF, 32'hDEAD_BEEF, 1'b0, 1'b0},
        '{12'h01C, 32'h7DFF_FFFF, 4'hF, 32'hFFFF_FFFF, 1'b0, 1'b0},
        '{12'h020, 32'h0100_0000, 4'hF, 32'h0100_0000, 1'b0, 1'b0},
        '{12'h024, 32'h0000_0000, 4'hF, 32'h0000_0000, 1'b0, 1'b0},
        '{12'h028, 32'hA5A5_5A5A, 4'hF, 32'hA5A5_5A5A, 1'b0, 1'b0},
        '{12'h02C, 32'h0000_0003, 4'hF, 32'h0000_0003, 1'b0, 1'b0},
        '{12'h008, 32'hFFFF_FFFF, 4'hF, 32'h0000_0000, 1'b1, 1'b1},
        '{12'h028, 32'h0000_0000, 4'h3, 32'hA5A5_5A5A, 1'b1, 1'b0},
        '{12'h026, 32'h0000_0000, 4'hF, 32'h0000_0000, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic apb(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       input logic [3:0] s, output logic [31:0] rd, output logic e);
        @(negedge clk);
        psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk);
        penable = 1;
        #1 rd = prdata;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        e = access_err;
    endtask

    task automatic reset_pulse();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic check_reset_values();
        logic [31:0] rd;
        logic e;
        // R1 R2 R6: reset values read back through the map
        apb(0, 12'h000, 0, 4'hF, rd, e); chk("R1 osc reset", rd, 32'hC000_0000);
        apb(0, 12'h004, 0, 4'hF, rd, e); chk("R1 core pll reset", rd, 32'h8201_87C1);
        apb(0, 12'h00C, 0, 4'hF, rd, e); chk("R1 ddr pll reset", rd, 32'h8201_87C1);
        apb(0, 12'h01C, 0, 4'hF, rd, e); chk("R1 eth pll reset", rd, 32'h8201_87C1);
        apb(0, 12'h010, 0, 4'hF, rd, e); chk("R1 ddr cfg1 reset", rd, 32'h0);
        apb(0, 12'h024, 0, 4'hF, rd, e); chk("R1 clk sel reset", rd, 32'h1);
        chk("R1 clk_sel_o reset", clk_sel_o, 32'h1);
        chk("R1 dev_rst_o reset", dev_rst_o, 32'h0);
        chk("R1 mux_status_o reset", mux_status_o, 32'h0);
        chk("R1 access_err reset", {31'b0, access_err}, 32'h0);
    endtask

    initial begin
        logic [31:0] rd;
        logic e;
        reset_pulse();
        check_reset_values();
        chk("R9 pready", {31'b0, pready}, 32'h1);

        // Table: write, then read back (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int i = 0; i < NV; i++) begin
            apb(1, VECS[i].addr, VECS[i].wdata, VECS[i].strb, rd, e);
            chk($sformatf("R9 R7 R8 write err vec %0d", i), {31'b0, e}, {31'b0, VECS[i].werr});
            apb(0, VECS[i].addr, 0, 4'hF, rd, e);
            chk($sformatf("R3 R4 R5 R6 readback vec %0d", i), rd, VECS[i].rd);
            chk($sformatf("R9 read err vec %0d", i), {31'b0, e}, {31'b0, VECS[i].rerr});
        end

        // R10 ports reflect the stored values
        chk("R10 osc port", osc_cfg_o, 32'h9234_5678);
        chk("R10 core pll port", core_pll_cfg0_o, 32'h8200_0000);
        chk("R10 eth pll port", eth_pll_cfg0_o, 32'hFFFF_FFFF);
        chk("R10 clk_sel port", clk_sel_o, 32'h0);
        chk("R7 R8 dev_rst port kept", dev_rst_o, 32'hA5A5_5A5A);
        chk("R10 mux status port", mux_status_o, 32'h3);

        // R8: partial strobe read returns zero with error
        apb(0, 12'h028, 0, 4'h1, rd, e);
        chk("R8 partial read data", rd, 32'h0);
        chk("R8 partial read err", {31'b0, e}, 32'h1);
        // R9: error lasts a single cycle
        @(negedge clk);
        chk("R9 err single cycle", {31'b0, access_err}, 32'h0);

        // R10: port old during access phase, new after the edge
        @(negedge clk);
        psel = 1; penable = 0; pwrite = 1; paddr = 12'h028; pwdata = 32'h0000_00F0; pstrb = 4'hF;
        @(negedge clk);
        penable = 1;
        chk("R10 port old in access phase", dev_rst_o, 32'hA5A5_5A5A);
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        chk("R10 port new after edge", dev_rst_o, 32'h0000_00F0);
        chk("R9 no err on good write", {31'b0, access_err}, 32'h0);

        // R1: second reset restores defaults
        reset_pulse();
        check_reset_values();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule